// File: doc/BRIEF.md
# Serial-Loaded Latched Switch Controller

This block is the digital control front end of a bank of on/off switches. A serial bit stream is clocked into a shift register, eight stages per device, and the register contents reach the switch-control outputs through a bank of level-sensitive latches. With the hold input low, the latches pass the register through continuously. With hold high, they freeze the switch pattern while a new pattern is shifted in behind it. A clear input acts at once, without waiting for a clock edge. It empties every register stage and every latch, which turns all switches off.

The top module builds a chain of `NUM_DEV` identical eight-channel devices. Each device's serial output feeds the next device's serial input, and all devices share the clock, clear and hold. The chain behaves as one long shift register. If a word is sent most significant bit first, a full run of `8*NUM_DEV` clocks leaves it on the switch outputs with the MSB on the highest output. The serial output of the last device is brought out so that chains can be extended further.

Top module: `swbank_chain`

## Requirements
- R1: On each rising clock edge with clear low, stage 0 of the first device takes `sdi`, every stage n takes the old value of stage n-1, and stage 0 of device d+1 takes the old stage 7 of device d.
- R2: While `hold` is low and clear is low, `sw_on` continuously equals the register stages. Bit `d*8+n` is stage n of device d, and a 1 means that switch is ON.
- R3: While `clr` is high, every stage and every latch is 0, so `sw_on` is all zeros and `sdo` is 0. This takes effect without a clock edge and overrides both `hold` and the clock.
- R4: While `hold` is high and clear is low, `sw_on` keeps its value however many bits are shifted in.
- R5: `sdo` is the last stage of the last device. A single 1 shifted in after a clear first appears on `sdo` after exactly `8*NUM_DEV` rising edges.
- R6: After `clr` falls, the register shifts normally from the next rising edge, starting from all zeros.
- R7: A word sent MSB first over exactly `8*NUM_DEV` clocks, with `hold` low, appears on `sw_on` unchanged. Its MSB is on `sw_on[8*NUM_DEV-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| clr | input | 1 | Asynchronous clear of all stages and latches, active high |
| hold | input | 1 | 1: latches keep their value; 0: latches follow the register |
| sdi | input | 1 | Serial data into stage 0 of the first device |
| sdo | output | 1 | Last stage of the last device |
| sw_on | output | 8*NUM_DEV | Switch controls, 1 = ON |

## Verification
The shift register is visible at `sdo` and, whenever hold is low, at every bit of `sw_on`. A wrong stage value therefore shows on the parallel outputs in the cycle it is created, and on `sdo` at the latest after `8*NUM_DEV` further clocks. A latch that leaks while hold is high shows as a changed `sw_on` during a hold phase, in the first cycle after the register moves. A clear that waits for a clock edge is caught by sampling the outputs one time unit after `clr` rises, away from any edge.

// File: rtl/swbank_pkg.sv
package swbank_pkg;
    localparam int DEV_CH = 8;

    typedef enum logic {
        LAT_FOLLOW = 1'b0,
        LAT_KEEP   = 1'b1
    } lat_mode_e;
endpackage

// File: rtl/swbank_shreg.sv
module swbank_shreg #(
    parameter int CH = swbank_pkg::DEV_CH
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          sin,
    output logic [CH-1:0] stage,
    output logic          sout
);
    typedef struct packed {
        logic [CH-1:0] stage;
    } sr_t;

    sr_t sr_d, sr_q;

    // next state: shift one place toward the top, serial input at the bottom
    always_comb begin
        sr_d       = sr_q;
        sr_d.stage = {sr_q.stage[CH-2:0], sin};
    end

    // clear empties the register without waiting for an edge
    always_ff @(posedge clk or posedge clr) begin
        if (clr) sr_q <= '0;
        else     sr_q <= sr_d;
    end

    assign stage = sr_q.stage;
    assign sout  = sr_q.stage[CH-1];
endmodule

// File: rtl/swbank_latchbank.sv
module swbank_latchbank #(
    parameter int CH = swbank_pkg::DEV_CH
) (
    input  logic          clr,
    input  logic          hold,
    input  logic [CH-1:0] din,
    output logic [CH-1:0] qout
);
    import swbank_pkg::*;

    lat_mode_e     mode;
    logic [CH-1:0] lat;

    assign mode = lat_mode_e'(hold);

    // clear has priority over the enable inside the same process
    always_latch begin
        if (clr)                     lat = '0;
        else if (mode == LAT_FOLLOW) lat = din;
    end

    assign qout = lat;
endmodule

// File: rtl/swbank_device.sv
module swbank_device #(
    parameter int CH = swbank_pkg::DEV_CH
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          hold,
    input  logic          sin,
    output logic          sout,
    output logic [CH-1:0] stage,
    output logic [CH-1:0] sw
);
    logic [CH-1:0] stage_w;

    swbank_shreg #(.CH(CH)) u_sr (
        .clk   (clk),
        .clr   (clr),
        .sin   (sin),
        .stage (stage_w),
        .sout  (sout)
    );

    swbank_latchbank #(.CH(CH)) u_lat (
        .clr  (clr),
        .hold (hold),
        .din  (stage_w),
        .qout (sw)
    );

    assign stage = stage_w;
endmodule

// File: rtl/swbank_chain.sv
module swbank_chain #(
    parameter int NUM_DEV = 2,
    parameter int CH      = swbank_pkg::DEV_CH
) (
    input  logic                  clk,
    input  logic                  clr,
    input  logic                  hold,
    input  logic                  sdi,
    output logic                  sdo,
    output logic [NUM_DEV*CH-1:0] sw_on
);
    localparam int TOT = NUM_DEV * CH;

    logic [NUM_DEV:0] link;
    logic [TOT-1:0]   stage_all;

    assign link[0] = sdi;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        swbank_device #(.CH(CH)) u_dev (
            .clk   (clk),
            .clr   (clr),
            .hold  (hold),
            .sin   (link[d]),
            .sout  (link[d+1]),
            .stage (stage_all[d*CH +: CH]),
            .sw    (sw_on[d*CH +: CH])
        );
    end

    assign sdo = link[NUM_DEV];
endmodule

// File: rtl/swbank_chain_chk.sv
module swbank_chain_chk #(
    parameter int NUM_DEV = 2,
    parameter int CH      = 8
) (
    input logic                  clk,
    input logic                  clr,
    input logic                  hold,
    input logic                  sdi,
    input logic                  sdo,
    input logic [NUM_DEV*CH-1:0] sw_on,
    input logic [NUM_DEV*CH-1:0] stage_all
);
    localparam int TOT = NUM_DEV * CH;

    // R1: each edge moves the whole chain up by one place
    a_r1_chain_shift: assert property (@(posedge clk) disable iff (clr)
        !$past(clr) |-> (stage_all[TOT-1:1] == $past(stage_all[TOT-2:0])
                         && stage_all[0] == $past(sdi)));

    // R2: transparent latches track the register
    a_r2_follow: assert property (@(posedge clk) disable iff (clr)
        !hold |-> (sw_on == stage_all));

    // R3: clear forces all outputs off whatever hold does
    a_r3_clear_off: assert property (@(negedge clk)
        clr |-> (sw_on == '0 && sdo == 1'b0));

    // R4: held latches do not move
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (clr)
        (hold && $past(hold) && !$past(clr)) |-> $stable(sw_on));

    // R5: serial output carries the previous top-but-one stage
    a_r5_sdo_tail: assert property (@(posedge clk) disable iff (clr)
        !$past(clr) |-> (sdo == $past(stage_all[TOT-2])));
endmodule

bind swbank_chain swbank_chain_chk #(.NUM_DEV(NUM_DEV), .CH(CH)) u_chk (
    .clk       (clk),
    .clr       (clr),
    .hold      (hold),
    .sdi       (sdi),
    .sdo       (sdo),
    .sw_on     (sw_on),
    .stage_all (stage_all)
);

// File: tb/swbank_chain_test.sv
module swbank_chain_test;
    localparam int PERIOD  = 10;
    localparam int NUM_DEV = 2;
    localparam int CH      = 8;
    localparam int TOT     = NUM_DEV * CH;

    logic           clk = 1'b0;
    logic           clr = 1'b1;
    logic           hold = 1'b0;
    logic           sdi = 1'b0;
    logic           sdo;
    logic [TOT-1:0] sw_on;

    logic [TOT-1:0] m_sr  = '0;
    logic [TOT-1:0] m_lat = '0;
    int checks = 0;
    int errors = 0;

    swbank_chain #(.NUM_DEV(NUM_DEV), .CH(CH)) uut (
        .clk(clk), .clr(clr), .hold(hold), .sdi(sdi), .sdo(sdo), .sw_on(sw_on)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [TOT-1:0] exp_sw, input logic exp_sdo);
        checks++;
        if (sw_on !== exp_sw || sdo !== exp_sdo) begin
            errors++;
            $display("FAIL %s: sw_on=%h sdo=%b expected sw_on=%h sdo=%b",
                     req, sw_on, sdo, exp_sw, exp_sdo);
        end
    endtask

    task automatic chk_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one serial bit at a falling edge, update model at the rising edge
    task automatic tick(input logic b, input string req);
        sdi = b;
        @(posedge clk);
        if (!clr) m_sr = {m_sr[TOT-2:0], b};
        if (clr) begin m_sr = '0; m_lat = '0; end
        else if (!hold) m_lat = m_sr;
        @(negedge clk);
        chk(req, m_lat, m_sr[TOT-1]);
    endtask

    task automatic set_hold(input logic v, input string req);
        hold = v;
        #1;
        if (!clr && !v) m_lat = m_sr;
        chk(req, m_lat, m_sr[TOT-1]);
    endtask

    task automatic load_msb_first(input logic [TOT-1:0] w, input string req);
        for (int i = TOT - 1; i >= 0; i--) tick(w[i], req);
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R3: reset state under clear
        @(negedge clk); @(negedge clk);
        chk("R3 reset", '0, 1'b0);
        clr = 1'b0;

        // R6: a 1 enters stage 0 on the first edge after release
        tick(1'b1, "R6 first edge");
        chk("R6 first edge value", TOT'(1), 1'b0);

        // R1 R2 R7: walking one and assorted words, MSB first
        for (int i = 0; i < TOT; i++) begin
            load_msb_first(TOT'(1) << i, "R1 R2 walk");
            chk("R7 walk word", TOT'(1) << i, (i == TOT - 1));
        end
        load_msb_first(16'hA5C3, "R1 R2 word");
        chk("R7 word A5C3", 16'hA5C3, 1'b1);
        load_msb_first(16'h0FF0, "R1 R2 word");
        chk("R7 word 0FF0", 16'h0FF0, 1'b0);

        // R4: hold keeps old pattern while a new one shifts in
        set_hold(1'b1, "R4 hold enter");
        load_msb_first(16'h3C5A, "R4 hold shift");
        chk("R4 held pattern", 16'h0FF0, 1'b0);
        set_hold(1'b0, "R2 release");
        chk("R2 released pattern", 16'h3C5A, 1'b0);

        // R5: latency of a single 1 to the serial output
        @(negedge clk);
        clr = 1'b1; #1;
        m_sr = '0; m_lat = '0;
        chk("R3 async clear", '0, 1'b0);
        @(negedge clk);
        clr = 1'b0;
        begin
            int n;
            tick(1'b1, "R5 inject");
            n = 1;
            while (sdo !== 1'b1 && n < 4 * TOT) begin
                tick(1'b0, "R5 travel");
                n++;
            end
            chk_val("R5 latency", n, TOT);
        end

        // R3: clear in the middle of a shift with hold high
        load_msb_first(16'hFFFF, "R1 fill");
        set_hold(1'b1, "R4 hold enter 2");
        for (int i = 0; i < 5; i++) tick(1'b0, "R4 partial shift");
        chk("R4 held fill", 16'hFFFF, m_sr[TOT-1]);
        #(PERIOD/4);
        clr = 1'b1; #1;
        m_sr = '0; m_lat = '0;
        chk("R3 clear overrides hold", '0, 1'b0);
        @(negedge clk);
        tick(1'b1, "R3 clock ignored");
        set_hold(1'b0, "R3 hold low under clear");
        @(negedge clk);
        clr = 1'b0;
        tick(1'b1, "R6 restart");
        chk("R6 restart from zero", TOT'(1), 1'b0);
        tick(1'b0, "R6 second");
        chk("R6 second edge", TOT'(2), 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule